// File: doc/BRIEF.md
# Addressed Three-Wire Control Word Receiver

This block takes control words from a host over three slow wires: an enable line, a data line and a bit clock. Each transfer has two phases. With the enable line low, the host clocks in an 8-bit device address, least significant bit first. With the enable line high, the host clocks in the payload. The block compares the address with a fixed device code. It keeps the most recent 44 payload bits. When the enable line falls after a transfer to this device with a full payload, it copies those 44 bits to its output word and raises a strobe for one system clock.

All three bus lines are asynchronous to the fast system clock. Each line passes through a two-flop synchroniser, and bus edges are found by comparing successive synchronised samples. A host that pads the payload to 48 bits, with four leading dummy bits, gets the same result as one that sends exactly 44 bits. Downstream logic decodes the fields of the word. This block only delivers the word.

Top module: `ser_ctl_rx`

## Requirements
- R1: After reset, `word_o` is all zeros and `word_vld_o` is low.
- R2: Address bits are taken on rising bus-clock edges while enable is low. The first bit sent is address bit 0. A transfer is addressed to this device only if the last 8 address bits equal 0x81.
- R3: After an address that does not match, the payload is ignored. No strobe is issued, and `word_o` keeps its previous value.
- R4: Payload bits are taken on rising bus-clock edges while enable is high. With exactly 44 payload bits, the first bit sent lands in `word_o[0]` and the 44th in `word_o[43]`.
- R5: With more than 44 payload bits (for example 48), only the last 44 are kept. The earliest bits are dropped.
- R6: If fewer than 44 payload bits have arrived when enable falls, the frame is discarded. No strobe is issued, and `word_o` is unchanged.
- R7: An accepted frame produces exactly one `word_vld_o` pulse, one system clock wide, after enable falls.
- R8: `word_o` does not change during a frame. It updates only together with the strobe, after enable falls.
- R9: If fewer than 8 address bits are sent, the frame is rejected. If more than 8 are sent, only the last 8 are compared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_ce | input | 1 | Bus enable line: low for the address phase, high for the payload phase |
| bus_dat | input | 1 | Bus serial data |
| bus_sck | input | 1 | Bus bit clock; data is taken on its rising edge |
| word_o | output | 44 | Last accepted control word |
| word_vld_o | output | 1 | One-cycle strobe when `word_o` takes a new word |

## Verification
The bench mixes random frames with directed corner cases. The random frames vary the address, the address length and the payload length (short, exact and padded), and a bench model predicts each result. A design that reverses the payload order, or keeps the first 44 bits instead of the last, gives the wrong word on padded or random frames. A design that ignores the count or the address strobes on short, truncated or foreign frames and overwrites the word. A design that commits early shows a changed word just before enable falls. A strobe that lasts more than one cycle is counted twice.

// File: rtl/ser_ctl_pkg.sv
package ser_ctl_pkg;
  localparam int SER_ADDR_W  = 8;
  localparam int SER_DATA_W  = 44;
  localparam logic [7:0] SER_DEV_CODE = 8'h81;

  // Decoded bus events after synchronisation
  typedef struct packed {
    logic ce_lvl;
    logic ce_rise;
    logic ce_fall;
    logic sck_rise;
    logic dat;
  } bus_evt_t;
endpackage

// File: rtl/ser_ctl_sync.sv
module ser_ctl_sync #(
  parameter int STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ce_i,
  input  logic                  dat_i,
  input  logic                  sck_i,
  output ser_ctl_pkg::bus_evt_t evt_o
);
  localparam int LINES = 3;

  logic [LINES-1:0] raw;
  logic [LINES-1:0] stg_q [STAGES];
  logic [LINES-1:0] lvl_q;
  logic [LINES-1:0] cur;

  assign raw = {sck_i, dat_i, ce_i};

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= '0;
          else        stg_q[s] <= raw;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= '0;
          else        stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign cur = stg_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= cur;
  end

  always_comb begin
    evt_o.ce_lvl   = cur[0];
    evt_o.ce_rise  = cur[0] & ~lvl_q[0];
    evt_o.ce_fall  = ~cur[0] & lvl_q[0];
    evt_o.dat      = cur[1];
    evt_o.sck_rise = cur[2] & ~lvl_q[2];
  end
endmodule

// File: rtl/ser_ctl_shift.sv
module ser_ctl_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] sr_o,
  output logic         full_o
);
  localparam int CNT_W = $clog2(W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(W);

  logic [W-1:0]     sr_q, sr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // newest bit enters at the top, so the oldest kept bit ends at index 0
  always_comb begin
    sr_d  = sr_q;
    cnt_d = cnt_q;
    if (clr_i) begin
      sr_d  = '0;
      cnt_d = '0;
    end else if (en_i) begin
      sr_d = {bit_i, sr_q[W-1:1]};
      if (cnt_q != FULL) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      cnt_q <= '0;
    end else begin
      sr_q  <= sr_d;
      cnt_q <= cnt_d;
    end
  end

  assign sr_o   = sr_q;
  assign full_o = (cnt_q == FULL);
endmodule

// File: rtl/ser_ctl_rx.sv
module ser_ctl_rx #(
  parameter int         ADDR_W   = ser_ctl_pkg::SER_ADDR_W,
  parameter int         DATA_W   = ser_ctl_pkg::SER_DATA_W,
  parameter logic [7:0] DEV_CODE = ser_ctl_pkg::SER_DEV_CODE,
  parameter int         SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_ce,
  input  logic              bus_dat,
  input  logic              bus_sck,
  output logic [DATA_W-1:0] word_o,
  output logic              word_vld_o
);
  localparam logic [ADDR_W-1:0] CODE = ADDR_W'(DEV_CODE);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ser_ctl_pkg::bus_evt_t evt;

  ser_ctl_sync #(.STAGES(SYNC_N)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .ce_i  (bus_ce),
    .dat_i (bus_dat),
    .sck_i (bus_sck),
    .evt_o (evt)
  );

  // address phase: enable low
  logic              addr_clr, addr_en, addr_full;
  logic [ADDR_W-1:0] addr_sr;

  assign addr_clr = evt.ce_fall;
  assign addr_en  = evt.sck_rise & ~evt.ce_lvl;

  ser_ctl_shift #(.W(ADDR_W)) u_addr (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr_i  (addr_clr),
    .en_i   (addr_en),
    .bit_i  (evt.dat),
    .sr_o   (addr_sr),
    .full_o (addr_full)
  );

  // payload phase: enable high, only after a matching address
  logic              sel_q, sel_d;
  logic              pay_clr, pay_en, pay_full;
  logic [DATA_W-1:0] pay_sr;

  assign pay_clr = evt.ce_rise;
  assign pay_en  = evt.sck_rise & evt.ce_lvl & sel_q;

  ser_ctl_shift #(.W(DATA_W)) u_pay (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .clr_i  (pay_clr),
    .en_i   (pay_en),
    .bit_i  (evt.dat),
    .sr_o   (pay_sr),
    .full_o (pay_full)
  );

  logic [DATA_W-1:0] word_q, word_d;
  logic              vld_q, vld_d;
  logic              commit;

  assign commit = evt.ce_fall & sel_q & pay_full;

  always_comb begin
    sel_d = sel_q;
    if (evt.ce_rise)      sel_d = addr_full & (addr_sr == CODE);
    else if (evt.ce_fall) sel_d = 1'b0;
  end

  always_comb begin
    word_d = word_q;
    vld_d  = 1'b0;
    if (commit) begin
      word_d = pay_sr;
      vld_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      sel_q  <= 1'b0;
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      sel_q  <= sel_d;
      word_q <= word_d;
      vld_q  <= vld_d;
    end
  end

  // taps for the bound checker
  logic ce_fall_w, sel_w, pay_full_w;
  assign ce_fall_w  = evt.ce_fall;
  assign sel_w      = sel_q;
  assign pay_full_w = pay_full;

  assign word_o     = word_q;
  assign word_vld_o = vld_q;
endmodule

// File: rtl/ser_ctl_rx_chk.sv
module ser_ctl_rx_chk #(
  parameter int DATA_W = 44
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] word_o,
  input logic              word_vld_o,
  input logic              ce_fall,
  input logic              sel,
  input logic              pay_full
);
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_o |=> !word_vld_o); // R7

  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld_o |-> $stable(word_o)); // R8

  AST_STROBE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(word_vld_o) |-> $past(ce_fall)); // R7

  AST_SHORT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_fall && !pay_full) |=> !word_vld_o); // R6

  AST_FOREIGN_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_fall && !sel) |=> !word_vld_o); // R3
endmodule

bind ser_ctl_rx ser_ctl_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_int_n),
  .word_o     (word_o),
  .word_vld_o (word_vld_o),
  .ce_fall    (ce_fall_w),
  .sel        (sel_w),
  .pay_full   (pay_full_w)
);

// File: tb/test_ser_ctl_rx.sv
`timescale 1ns/100ps
module test_ser_ctl_rx;
  localparam int H = 5; // system clocks per bus half period

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_ce = 1'b0;
  logic        bus_dat = 1'b0;
  logic        bus_sck = 1'b0;
  logic [43:0] word_o;
  logic        word_vld_o;

  int checks = 0;
  int failures = 0;
  int strobes = 0;
  bit done = 0;
  logic [43:0] model_w = '0;

  always #2.5 clk = ~clk;

  ser_ctl_rx i_ser_ctl_rx (
    .clk(clk), .rst_n(rst_n), .bus_ce(bus_ce), .bus_dat(bus_dat),
    .bus_sck(bus_sck), .word_o(word_o), .word_vld_o(word_vld_o)
  );

  always @(negedge clk) if (rst_n && word_vld_o) strobes++;

  function automatic bit addr_match(input logic [15:0] ab, input int na);
    logic [7:0] c;
    if (na < 8) return 1'b0;
    for (int k = 0; k < 8; k++) c[k] = ab[na-8+k];
    return c == 8'h81;
  endfunction

  function automatic logic [43:0] last44(input logic [63:0] pb, input int np);
    logic [43:0] w;
    for (int i = 0; i < 44; i++) w[i] = pb[np-44+i];
    return w;
  endfunction

  task automatic chk_w(input string req, input logic [43:0] act, input logic [43:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s word act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic chk_i(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s count act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic bus_bit(input logic b);
    @(negedge clk) bus_dat = b;
    repeat (H) @(negedge clk);
    bus_sck = 1'b1;
    repeat (H) @(negedge clk);
    bus_sck = 1'b0;
  endtask

  task automatic send_frame(input logic [15:0] ab, input int na,
                            input logic [63:0] pb, input int np, input string req);
    bit          ok;
    logic [43:0] exp_w;
    int          s0;
    ok    = addr_match(ab, na) && (np >= 44);
    exp_w = ok ? last44(pb, np) : model_w;
    s0    = strobes;
    for (int k = 0; k < na; k++) bus_bit(ab[k]);
    repeat (H) @(negedge clk);
    bus_ce = 1'b1;
    repeat (H) @(negedge clk);
    for (int k = 0; k < np; k++) bus_bit(pb[k]);
    repeat (H) @(negedge clk);
    chk_w({req, " R8 before commit"}, word_o, model_w);
    bus_ce = 1'b0;
    repeat (12) @(negedge clk);
    chk_i({req, " R7 strobe count"}, strobes - s0, ok ? 1 : 0);
    chk_w(req, word_o, exp_w);
    model_w = exp_w;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] pb;
    process::self().srandom(32'd1357);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_w("R1 reset word", word_o, '0);
    chk_i("R1 reset strobe", int'(word_vld_o), 0);

    pb = {20'h0, 44'hA5C_3F01_9E7B};
    send_frame(16'h0081, 8, pb, 44, "R2 R4 exact frame");
    pb = {16'h0, 48'h1234_5678_9ABF};
    send_frame(16'h0081, 8, pb, 48, "R5 padded frame");
    pb = {20'h0, 44'hFFF_FFFF_FFFF};
    send_frame(16'h0018, 8, pb, 44, "R3 foreign address");
    send_frame(16'h0081, 8, pb, 43, "R6 short payload");
    send_frame(16'h0001, 7, pb, 44, "R9 short address");
    pb = {20'h0, 44'h0F0_0F0F_00F0};
    send_frame(16'h0207, 10, pb, 44, "R9 long address");
    send_frame(16'h0081, 8, pb, 0, "R6 empty payload");

    for (int n = 0; n < 30; n++) begin
      logic [15:0] ab;
      int          na, np, sel;
      pb  = {$urandom, $urandom};
      sel = $urandom_range(0, 5);
      na  = 8;
      ab  = 16'h0081;
      if (sel == 0) ab = 16'($urandom);
      if (sel == 1) na = $urandom_range(6, 12);
      if (na > 8) ab = (16'($urandom) & ~(16'hFFFF << (na - 8))) | (16'h0081 << (na - 8));
      case ($urandom_range(0, 3))
        0: np = $urandom_range(30, 43);
        1: np = 48;
        default: np = 44;
      endcase
      send_frame(ab, na, pb, np, "R4 R5 random frame");
    end

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule